// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block merges eight peripheral request lines into one interrupt line for a processor. Each line has a one-bit pending latch. A per-line mask register decides which pending requests may compete. A fixed priority then chooses a single winner, where line 0 is the most urgent and line 7 the least. The processor acknowledges the interrupt with `inta_i`. In that same cycle the block drives an 8-bit interrupt type, equal to a vector base plus the winning line's index, and moves the winner from pending to in-service.

In-service levels are held until software writes the end-of-interrupt code to the command register. While a level is in service, requests of equal or lower priority stay latched and do not raise the interrupt output. A strictly more urgent request raises the output again, so service routines can nest. Software reaches the block through a small register port with two registers: a mask register that can be written and read back, and a command register that can only be written.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `int_o` is low and the mask register reads back 00h, which means every line is enabled.
- R2: A low-to-high transition on `irq_req_i[i]` sets pending bit i at the next clock edge, and `int_o` follows in that same cycle. Further transitions on line i before it is acknowledged merge into the one pending request.
- R3: When several eligible requests are pending, the lowest-numbered line wins. It is the line whose type is driven and the line that is acknowledged first.
- R4: Writing with `reg_sel_i`=1 loads the mask register, and a read with `reg_sel_i`=1 returns it. Mask bit i = 1 keeps line i from raising `int_o`, but its pending bit is kept. Clearing the mask bit later lets the held request raise `int_o`.
- R5: In a cycle where `inta_i` and `int_o` are both high, `int_type_o` equals the base (default 08h) plus the index of the winning line. At the following edge that line leaves pending and enters service, and `int_o` drops if no other request qualifies.
- R6: A request on a line of lower or equal priority than the most urgent in-service level does not raise `int_o`. It stays pending until that level is ended.
- R7: A request on a line strictly more urgent than every in-service level raises `int_o`, which allows nesting.
- R8: Writing 20h with `reg_sel_i`=0 is end-of-interrupt. It clears only the most urgent in-service level. Command writes of any other value change nothing.
- R9: An `inta_i` pulse while `int_o` is low changes no pending or in-service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req_i | input | 8 | Peripheral request lines, bit 0 most urgent |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 command, 1 mask |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Mask when `reg_sel_i`=1, otherwise 00h |
| int_o | output | 1 | Interrupt request to the processor |
| inta_i | input | 1 | Interrupt acknowledge pulse, one cycle |
| int_type_o | output | 8 | Interrupt type, valid while `inta_i` is high |

## Verification
The bench pulses a line several times before acknowledging it. A design that counts requests instead of latching one would raise a second, phantom interrupt. It sends a low-priority request while a high level is in service, then issues a non-EOI command write and a real EOI. A design that ignores in-service state would interrupt too early, and one that decodes every command value as EOI would release the request at the wrong write. It also tests nesting, re-requests at the level already in service, requests held back by the mask, and an acknowledge that arrives with no interrupt raised. A design that consumed state on that stray acknowledge would lose the request that is held back by the mask.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned DW = 8;
  localparam logic [DW-1:0] EOI_CMD = 8'h20;
  typedef enum logic {
    SEL_CMD  = 1'b0,
    SEL_MASK = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/vic_rst_sync.sv
module vic_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/vic_pri_find.sv
module vic_pri_find #(
  parameter int unsigned N  = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vic_req_latch.sv
module vic_req_latch #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] req_q, pend_q, pend_d, rise;

  always_comb begin
    rise   = req_i & ~req_q;
    pend_d = (pend_q & ~clr_i) | rise;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= req_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  AST_RISE_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise) |=> ((pend_q & $past(rise)) == $past(rise))); // R2
endmodule

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter logic [DW-1:0] MASK_RST = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] mask_o,
  output logic          eoi_o
);
  logic [DW-1:0] mask_q, mask_d;
  logic          mask_en;

  always_comb begin
    mask_en = we_i && (sel_i == SEL_MASK);
    mask_d  = mask_en ? wdata_i : mask_q;
    eoi_o   = we_i && (sel_i == SEL_CMD) && (wdata_i == EOI_CMD);
    rdata_o = (sel_i == SEL_MASK) ? mask_q : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= MASK_RST;
    else         mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  AST_MASK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && sel_i == SEL_MASK) |=> $stable(mask_q)); // R4
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned   N_LINES  = 8,
  parameter logic [DW-1:0] VEC_BASE = 8'h08,
  parameter logic [DW-1:0] MASK_RST = 8'h00
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    irq_req_i,
  input  logic          reg_we_i,
  input  logic          reg_sel_i,
  input  logic [7:0]    reg_wdata_i,
  output logic [7:0]    reg_rdata_o,
  output logic          int_o,
  input  logic          inta_i,
  output logic [7:0]    int_type_o
);
  localparam int unsigned IW = $clog2(N_LINES);

  logic               rst_n;
  logic [N_LINES-1:0] pend, mask_l, eligible, isr_q, isr_d, ack_clr, eoi_clr;
  logic [DW-1:0]      mask_full;
  logic               eoi, ack_take, p_found, s_found;
  logic [IW-1:0]      p_idx, s_idx;

  vic_rst_sync u_rst (.clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n));

  vic_regs #(.MASK_RST(MASK_RST)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_n), .we_i(reg_we_i), .sel_i(reg_sel_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .mask_o(mask_full),
    .eoi_o(eoi)
  );

  vic_req_latch #(.N(N_LINES)) u_latch (
    .clk_i(clk_i), .rst_ni(rst_n), .req_i(irq_req_i[N_LINES-1:0]),
    .clr_i(ack_clr), .pend_o(pend)
  );

  vic_pri_find #(.N(N_LINES)) u_pend_pri (
    .vec_i(eligible), .found_o(p_found), .idx_o(p_idx)
  );

  vic_pri_find #(.N(N_LINES)) u_isr_pri (
    .vec_i(isr_q), .found_o(s_found), .idx_o(s_idx)
  );

  always_comb begin
    mask_l     = mask_full[N_LINES-1:0];
    eligible   = pend & ~mask_l;
    int_o      = p_found && (!s_found || (p_idx < s_idx));
    ack_take   = inta_i && int_o;
    ack_clr    = ack_take ? (N_LINES'(1) << p_idx) : '0;
    eoi_clr    = (eoi && s_found) ? (N_LINES'(1) << s_idx) : '0;
    isr_d      = (isr_q & ~eoi_clr) | ack_clr;
    int_type_o = VEC_BASE + DW'(p_idx);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= isr_d;
  end

  AST_ACK_ENTERS_SERVICE: assert property (@(posedge clk_i) disable iff (!rst_n)
    ack_take |=> isr_q[$past(p_idx)]); // R5
  AST_TOP_LEVEL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_n)
    isr_q[0] |-> !int_o); // R6
  AST_EOI_ONE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_n)
    (eoi && !ack_take && (|isr_q)) |=>
      ($countones(isr_q) == $countones($past(isr_q)) - 1)); // R8
  AST_IDLE_KEEPS_ISR: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!ack_take && !eoi) |=> $stable(isr_q)); // R9
  AST_TYPE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_n)
    int_o |-> ((int_type_o - VEC_BASE) < DW'(N_LINES))); // R5
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0;
  logic       we = 1'b0, sel = 1'b0, inta = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, itype;
  logic       irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req), .reg_we_i(we),
    .reg_sel_i(sel), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .int_o(irq), .inta_i(inta), .int_type_o(itype)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [7:0] lines);
    @(negedge clk) req = lines;
    @(negedge clk) req = '0;
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk) begin we = 1'b1; sel = s; wdata = d; end
    @(negedge clk) begin we = 1'b0; sel = 1'b0; end
  endtask

  task automatic ack(input string tag, input logic [7:0] exp_type);
    @(negedge clk) inta = 1'b1;
    #2;
    chk(tag, itype, exp_type);
    @(negedge clk) inta = 1'b0;
  endtask

  task automatic irq_is(input string tag, input logic exp);
    #1 chk(tag, {7'b0, irq}, {7'b0, exp});
  endtask

  task automatic t_reset;
    irq_is("R1 irq after reset", 1'b0);
    sel = 1'b1; #1;
    chk("R1 mask reset value", rdata, 8'h00);
    sel = 1'b0;
  endtask

  task automatic t_collapse;
    pulse(8'h10); pulse(8'h10); pulse(8'h10);
    irq_is("R2 irq after IR4 pulses", 1'b1);
    ack("R5 type for IR4", 8'h0C);
    irq_is("R5 irq drops after ack", 1'b0);
    wr(1'b0, 8'h20);
    irq_is("R2 repeated pulses merged", 1'b0);
  endtask

  task automatic t_priority;
    pulse(8'h28);
    ack("R3 IR3 beats IR5", 8'h0B);
    wr(1'b0, 8'h20);
    irq_is("R3 IR5 follows", 1'b1);
    ack("R3 then IR5", 8'h0D);
    wr(1'b0, 8'h20);
    irq_is("R3 all served", 1'b0);
  endtask

  task automatic t_mask;
    wr(1'b1, 8'h02);
    sel = 1'b1; #1;
    chk("R4 mask readback", rdata, 8'h02);
    sel = 1'b0;
    pulse(8'h02);
    irq_is("R4 masked IR1 silent", 1'b0);
    wr(1'b1, 8'h00);
    irq_is("R4 unmask releases IR1", 1'b1);
    ack("R4 IR1 type", 8'h09);
    wr(1'b0, 8'h20);
  endtask

  task automatic t_low_waits;
    pulse(8'h04);
    ack("R5 IR2 type", 8'h0A);
    pulse(8'h40);
    irq_is("R6 IR6 held under IR2", 1'b0);
    wr(1'b0, 8'h21);
    irq_is("R8 non-EOI value ignored", 1'b0);
    wr(1'b0, 8'h20);
    irq_is("R6 IR6 after EOI", 1'b1);
    ack("R6 IR6 type", 8'h0E);
    wr(1'b0, 8'h20);
    irq_is("R8 idle after EOI", 1'b0);
  endtask

  task automatic t_nest;
    pulse(8'h20);
    ack("R7 IR5 type", 8'h0D);
    pulse(8'h01);
    irq_is("R7 IR0 nests over IR5", 1'b1);
    ack("R7 IR0 type", 8'h08);
    wr(1'b0, 8'h20);
    irq_is("R8 EOI ends IR0 only", 1'b0);
    pulse(8'h80);
    irq_is("R8 IR5 still in service", 1'b0);
    wr(1'b0, 8'h20);
    irq_is("R8 second EOI ends IR5", 1'b1);
    ack("R8 IR7 type", 8'h0F);
    wr(1'b0, 8'h20);
  endtask

  task automatic t_same_level;
    pulse(8'h08);
    ack("R6 IR3 type", 8'h0B);
    pulse(8'h08);
    irq_is("R6 same level held", 1'b0);
    wr(1'b0, 8'h20);
    irq_is("R6 same level after EOI", 1'b1);
    ack("R6 IR3 again", 8'h0B);
    wr(1'b0, 8'h20);
  endtask

  task automatic t_stray_ack;
    wr(1'b1, 8'h01);
    pulse(8'h01);
    irq_is("R9 masked IR0 silent", 1'b0);
    @(negedge clk) inta = 1'b1;
    @(negedge clk) inta = 1'b0;
    wr(1'b1, 8'h00);
    irq_is("R9 stray ack kept IR0", 1'b1);
    ack("R9 IR0 type", 8'h08);
    wr(1'b0, 8'h20);
    irq_is("R9 final idle", 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_collapse();
    t_priority();
    t_mask();
    t_low_waits();
    t_nest();
    t_same_level();
    t_stray_ack();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule